// File: doc/BRIEF.md
# Cascadable Decimal Digit Adder

This block adds two packed decimal numbers of `DIGITS` digits plus an incoming carry, entirely in combinational logic. Each digit slice forms a 5-bit binary total of its two 4-bit operand digits and its carry, then folds any total of ten or more back into a single decimal digit and raises a carry toward the next more significant slice. Inside a slice the binary carry is produced by look-ahead equations, so the only ripple path is the one-bit carry handed from slice to slice. Digit 0 sits in bits [3:0] and is the least significant digit.

A slice also accepts operand codes 10 to 15. It does not reject them: it folds them like any other total. With one operand held at zero, a slice therefore works as a binary-to-decimal converter. A 4-bit binary value comes out as a units digit plus a tens carry, and the tens carry lands in the next slice.

A parameter chooses how the 4-bit binary total inside each slice is built: look-ahead equations, or a plain bit-serial ripple. Both variants produce identical results.

Top module: `bcd_chain_adder`

## Requirements
- R1: In a slice whose total T = A + B + carry-in is 9 or less, the slice's carry-out is 0 and its sum digit equals T.
- R2: In a slice whose total T is 10 or more (T ranges 0 to 31), the carry-out is 1 and the sum digit is (T - 10) mod 16.
- R3: With one operand zero, carry-in 0, and the other operand digit between 0 and 9, the sum digit reproduces that operand and the carry-out is 0.
- R4: With one operand zero, carry-in 0, and the other operand digit between 10 and 15, the carry-out is 1 and the sum digit is the operand minus 10.
- R5: For operands whose digits are all 0 to 9, `sum_bcd` holds the decimal value (A + B + carry_in) mod 10^DIGITS as packed digits, each at most 9, and `carry_out` is 1 exactly when A + B + carry_in is at least 10^DIGITS.
- R6: Digit k occupies bits [4k+3:4k]. `carry_in` enters digit 0, each slice's carry feeds digit k+1, and the last slice's carry drives `carry_out`. Sum bit 0 always equals a[0] ^ b[0] ^ carry_in.
- R7: With `LOOKAHEAD` = 1 the slices use carry look-ahead; with `LOOKAHEAD` = 0 they use a bit ripple. Both settings give identical `sum_bcd` and `carry_out` for every input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_bcd | input | 4*DIGITS | First packed operand, digit 0 in bits [3:0] |
| b_bcd | input | 4*DIGITS | Second packed operand, same layout |
| carry_in | input | 1 | Carry into the least significant digit |
| sum_bcd | output | 4*DIGITS | Packed decimal sum digits |
| carry_out | output | 1 | Carry out of the most significant digit |

## Verification
The bench builds three instances:
- A one-digit instance. All 512 combinations of two 4-bit digits and a carry are swept through it, which covers every total from 0 to 31, including the wrapped outputs for totals of 20 and above.
- Two four-digit instances, one with look-ahead slices and one with ripple slices. These are driven with a table of directed cases and with random decimal operands checked against integer arithmetic. The directed cases include carry propagating across every digit, overflow out of the top digit, and conversion of non-decimal codes in upper digit positions. Comparing the two instances on every vector shows that the two binary-total variants agree.

// File: rtl/bcd_pkg.sv
package bcd_pkg;
   localparam int unsigned NIB_W   = 4;
   localparam int unsigned TOT_W   = NIB_W + 1;
   localparam int unsigned DEC_MAX = 9;
   localparam int unsigned FOLD_ADJ = 6;  // 16 - 10, added to drop a decade

   typedef logic [NIB_W-1:0] nib_t;
   typedef logic [TOT_W-1:0] tot_t;

   function automatic logic nib_is_decimal(input nib_t v);
      return v <= nib_t'(DEC_MAX);
   endfunction
endpackage

// File: rtl/bcd_bin_nibble_add.sv
module bcd_bin_nibble_add
   import bcd_pkg::*;
#(
   parameter bit LOOKAHEAD = 1'b1
) (
   input  nib_t a_i,
   input  nib_t b_i,
   input  logic ci_i,
   output tot_t tot_o
);
   localparam int unsigned W = NIB_W;

   nib_t gen, prop;
   logic [W:0] cy;

   assign gen  = a_i & b_i;
   assign prop = a_i ^ b_i;

   generate
      if (LOOKAHEAD) begin : g_cla
         assign cy[0] = ci_i;
         assign cy[1] = gen[0] | (prop[0] & ci_i);
         assign cy[2] = gen[1] | (prop[1] & gen[0]) | (prop[1] & prop[0] & ci_i);
         assign cy[3] = gen[2] | (prop[2] & gen[1]) | (prop[2] & prop[1] & gen[0])
                      | (prop[2] & prop[1] & prop[0] & ci_i);
         assign cy[4] = gen[3] | (prop[3] & gen[2]) | (prop[3] & prop[2] & gen[1])
                      | (prop[3] & prop[2] & prop[1] & gen[0])
                      | (prop[3] & prop[2] & prop[1] & prop[0] & ci_i);
      end else begin : g_ripple
         assign cy[0] = ci_i;
         for (genvar i = 0; i < W; i++) begin : g_bit
            assign cy[i+1] = gen[i] | (prop[i] & cy[i]);
         end
      end
   endgenerate

   assign tot_o = {cy[W], prop ^ cy[W-1:0]};
endmodule

// File: rtl/bcd_digit_fold.sv
module bcd_digit_fold
   import bcd_pkg::*;
(
   input  tot_t tot_i,
   output nib_t digit_o,
   output logic carry_o
);
   // A total of ten or more: bit 4 set (16..31) or low nibble 10..15.
   logic over_nine;
   assign over_nine = tot_i[4] | (tot_i[3] & (tot_i[2] | tot_i[1]));
   assign carry_o   = over_nine;
   assign digit_o   = tot_i[NIB_W-1:0] + (over_nine ? nib_t'(FOLD_ADJ) : nib_t'(0));
endmodule

// File: rtl/bcd_digit_stage.sv
module bcd_digit_stage
   import bcd_pkg::*;
#(
   parameter bit LOOKAHEAD = 1'b1
) (
   input  nib_t a_i,
   input  nib_t b_i,
   input  logic ci_i,
   output nib_t s_o,
   output logic co_o
);
   tot_t total;

   bcd_bin_nibble_add #(.LOOKAHEAD(LOOKAHEAD)) add_i (
      .a_i   (a_i),
      .b_i   (b_i),
      .ci_i  (ci_i),
      .tot_o (total)
   );

   bcd_digit_fold fold_i (
      .tot_i   (total),
      .digit_o (s_o),
      .carry_o (co_o)
   );
endmodule

// File: rtl/bcd_chain_adder.sv
module bcd_chain_adder
   import bcd_pkg::*;
#(
   parameter int unsigned DIGITS    = 4,
   parameter bit          LOOKAHEAD = 1'b1
) (
   input  logic [NIB_W*DIGITS-1:0] a_bcd,
   input  logic [NIB_W*DIGITS-1:0] b_bcd,
   input  logic                    carry_in,
   output logic [NIB_W*DIGITS-1:0] sum_bcd,
   output logic                    carry_out
);
   localparam int unsigned BUS_W = NIB_W * DIGITS;

   initial begin
      if (DIGITS < 1 || DIGITS > 15)
         $error("bcd_chain_adder: DIGITS must be 1..15, got %0d", DIGITS);
   end

   logic [DIGITS:0] chain;
   assign chain[0] = carry_in;

   generate
      for (genvar k = 0; k < DIGITS; k++) begin : g_digit
         bcd_digit_stage #(.LOOKAHEAD(LOOKAHEAD)) stage_i (
            .a_i  (a_bcd[NIB_W*k +: NIB_W]),
            .b_i  (b_bcd[NIB_W*k +: NIB_W]),
            .ci_i (chain[k]),
            .s_o  (sum_bcd[NIB_W*k +: NIB_W]),
            .co_o (chain[k+1])
         );
      end
   endgenerate

   assign carry_out = chain[DIGITS];

   logic unused_w;
   assign unused_w = ^BUS_W[0];
endmodule

// File: rtl/bcd_chain_adder_chk.sv
module bcd_chain_adder_chk
   import bcd_pkg::*;
#(
   parameter int unsigned DIGITS = 4
) (
   input logic [NIB_W*DIGITS-1:0] a_bcd,
   input logic [NIB_W*DIGITS-1:0] b_bcd,
   input logic                    carry_in,
   input logic [NIB_W*DIGITS-1:0] sum_bcd,
   input logic                    carry_out
);
   function automatic bit all_dec(input logic [NIB_W*DIGITS-1:0] v);
      for (int k = 0; k < DIGITS; k++)
         if (!nib_is_decimal(v[NIB_W*k +: NIB_W])) return 1'b0;
      return 1'b1;
   endfunction

   function automatic longint dec_val(input logic [NIB_W*DIGITS-1:0] v);
      longint r = 0;
      for (int k = DIGITS - 1; k >= 0; k--)
         r = r * 10 + longint'(v[NIB_W*k +: NIB_W]);
      return r;
   endfunction

   function automatic longint decade_span();
      longint r = 1;
      for (int k = 0; k < DIGITS; k++) r = r * 10;
      return r;
   endfunction

   always_comb begin
      if (all_dec(a_bcd) && all_dec(b_bcd)) begin
         // R5: result digits stay decimal and the value matches integer addition
         assert_digits_decimal_R5: assert (all_dec(sum_bcd));
         assert_value_R5: assert (dec_val(sum_bcd) + (carry_out ? decade_span() : 64'sd0)
                                  == dec_val(a_bcd) + dec_val(b_bcd) + longint'(carry_in));
      end
   end

   always_comb begin
      // R1: an all-zero input gives an all-zero output
      if (a_bcd == '0 && b_bcd == '0 && !carry_in)
         assert_zero_total_R1: assert (sum_bcd == '0 && !carry_out);
   end

   always_comb begin
      // R3: zero second operand passes a decimal first operand straight through
      if (b_bcd == '0 && !carry_in && all_dec(a_bcd))
         assert_passthrough_R3: assert (sum_bcd == a_bcd && !carry_out);
   end

   always_comb begin
      // R4: least significant digit folds a code of 10..15 down by ten
      if (b_bcd[NIB_W-1:0] == '0 && !carry_in && !nib_is_decimal(a_bcd[NIB_W-1:0]))
         assert_fold_low_R4: assert (sum_bcd[NIB_W-1:0] == a_bcd[NIB_W-1:0] - nib_t'(10));
   end

   always_comb begin
      // R6: the incoming carry enters the least significant digit
      assert_lsb_parity_R6: assert (sum_bcd[0] == (a_bcd[0] ^ b_bcd[0] ^ carry_in));
   end
endmodule

bind bcd_chain_adder bcd_chain_adder_chk #(.DIGITS(DIGITS)) chk_i (
   .a_bcd     (a_bcd),
   .b_bcd     (b_bcd),
   .carry_in  (carry_in),
   .sum_bcd   (sum_bcd),
   .carry_out (carry_out)
);

// File: tb/bcd_chain_adder_tb_top.sv
module bcd_chain_adder_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int ND = 4;
   localparam int BW = 4 * ND;
   localparam int NVEC = 9;

   typedef struct packed {
      logic [BW-1:0] a;
      logic [BW-1:0] b;
      logic          ci;
      logic [BW-1:0] s;
      logic          co;
   } vec_t;

   localparam vec_t VECS [NVEC] = '{
      '{16'h0000, 16'h0000, 1'b0, 16'h0000, 1'b0},
      '{16'h1234, 16'h4321, 1'b0, 16'h5555, 1'b0},
      '{16'h9999, 16'h0001, 1'b0, 16'h0000, 1'b1},
      '{16'h0999, 16'h0000, 1'b1, 16'h1000, 1'b0},
      '{16'h5678, 16'h4321, 1'b1, 16'h0000, 1'b1},
      '{16'h0000, 16'h000F, 1'b0, 16'h0015, 1'b0},
      '{16'h00A0, 16'h0000, 1'b0, 16'h0100, 1'b0},
      '{16'h0FFF, 16'h0FFF, 1'b0, 16'h1554, 1'b0},
      '{16'h4567, 16'h5433, 1'b0, 16'h0000, 1'b1}
   };

   logic clk = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   logic [BW-1:0] a, b, s_la, s_rp;
   logic ci, co_la, co_rp;
   logic [3:0] a1, b1, s1;
   logic ci1, co1;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   bcd_chain_adder #(.DIGITS(ND), .LOOKAHEAD(1'b1)) dut_i (
      .a_bcd(a), .b_bcd(b), .carry_in(ci), .sum_bcd(s_la), .carry_out(co_la));
   bcd_chain_adder #(.DIGITS(ND), .LOOKAHEAD(1'b0)) dut_rip_i (
      .a_bcd(a), .b_bcd(b), .carry_in(ci), .sum_bcd(s_rp), .carry_out(co_rp));
   bcd_chain_adder #(.DIGITS(1), .LOOKAHEAD(1'b1)) dut_one_i (
      .a_bcd(a1), .b_bcd(b1), .carry_in(ci1), .sum_bcd(s1), .carry_out(co1));

   task automatic check(input string req, input logic [BW:0] act, input logic [BW:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [BW-1:0] to_bcd(input int v);
      logic [BW-1:0] r = '0;
      for (int k = 0; k < ND; k++) begin
         r[4*k +: 4] = 4'(v % 10);
         v = v / 10;
      end
      return r;
   endfunction

   task automatic drive4(input logic [BW-1:0] av, input logic [BW-1:0] bv, input logic c);
      @(negedge clk);
      a = av; b = bv; ci = c;
      @(posedge clk);
      #1;
   endtask

   initial begin
      a = '0; b = '0; ci = 1'b0; a1 = '0; b1 = '0; ci1 = 1'b0;
      @(posedge clk); #1;
      // idle state with all inputs low: R1
      check("R1 idle zero", {co_la, s_la}, '0);

      // directed table: R5 chaining, R6 placement, R4 folding in upper digits
      for (int i = 0; i < NVEC; i++) begin
         drive4(VECS[i].a, VECS[i].b, VECS[i].ci);
         check("R5 table", {co_la, s_la}, {VECS[i].co, VECS[i].s});
         check("R7 table variant", {co_rp, s_rp}, {co_la, s_la});
      end

      // exhaustive single slice: R1 R2 R3 R4
      for (int x = 0; x < 16; x++) begin
         for (int y = 0; y < 16; y++) begin
            for (int c = 0; c < 2; c++) begin
               int t;
               logic [4:0] e;
               @(negedge clk);
               a1 = 4'(x); b1 = 4'(y); ci1 = 1'(c);
               @(posedge clk); #1;
               t = x + y + c;
               e = (t >= 10) ? {1'b1, 4'(t - 10)} : {1'b0, 4'(t)};
               if (y == 0 && c == 0 && x <= 9)
                  check("R3 pass-through", {co1, s1}, e);
               else if (y == 0 && c == 0)
                  check("R4 fold", {co1, s1}, e);
               else if (t >= 10)
                  check("R2 decimal carry", {co1, s1}, e);
               else
                  check("R1 no carry", {co1, s1}, e);
            end
         end
      end

      // random decimal operands: R5 and R7
      for (int i = 0; i < 300; i++) begin
         int x, y, c, t;
         x = int'($urandom_range(9999, 0));
         y = int'($urandom_range(9999, 0));
         c = int'($urandom_range(1, 0));
         drive4(to_bcd(x), to_bcd(y), 1'(c));
         t = x + y + c;
         check("R5 random", {co_la, s_la}, {(t >= 10000), to_bcd(t % 10000)});
         check("R7 random variant", {co_rp, s_rp}, {co_la, s_la});
      end

      // carry ripples through every digit into the top: R6
      drive4(16'h9999, 16'h0000, 1'b1);
      check("R6 full ripple", {co_la, s_la}, {1'b1, 16'h0000});
      drive4(16'h0000, 16'h0000, 1'b1);
      check("R6 carry into digit 0", {co_la, s_la}, {1'b0, 16'h0001});
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (50000) @(posedge clk);
            fails++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
         end
      join_any
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule